// File: doc/BRIEF.md
# Interrupt Enable and Pending Controller

This block keeps the enable, pending and priority state for up to 256 interrupt lines of a vectored interrupt controller. It picks the one interrupt to be serviced next. Software reaches the state through a plain 32-bit register bus with a word address, a write strobe, write data and combinational read data. A write lands on the next rising clock edge.

A line that is high on a clock edge is latched as pending, whether or not it is enabled. Only interrupts that are both pending and enabled compete. Of those, the one with the smallest priority value wins, and equal values go to the lower interrupt number. The winner's number and a valid flag are combinational outputs of the registered state. An acknowledge input that carries the winner's number retires that interrupt's pending bit. Activation, stacking and preemption belong to the processor side and are not part of this block.

Word map for the default of 256 lines: set-enable words at 0..7, clear-enable words at 8..15, set-pending words at 16..23, clear-pending words at 24..31, priority words at 32..95. In an enable or pending word w, bit b stands for interrupt 32*w+b.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every enable bit, pending bit and priority byte reads back as zero and `win_valid` is low.
- R2: A write to set-enable word w (address w, 0..7) enables every interrupt whose bit is 1 and leaves interrupts with a 0 bit unchanged. A read of the word returns 1 for enabled and 0 for disabled interrupts.
- R3: A write to clear-enable word w (address 8+w) disables every interrupt whose bit is 1 and leaves the rest unchanged. A read of that address returns the same enable state as address w.
- R4: An interrupt line that is high on a clock edge sets its pending bit, whether or not the interrupt is enabled. The bit stays set after the line falls.
- R5: A write to set-pending word w (address 16+w) sets the pending bits written as 1. A write to clear-pending word w (address 24+w) clears the pending bits written as 1. A read of either address returns the current pending bits.
- R6: Priority word k (address 32+k) holds the 8-bit priorities of interrupts 4k..4k+3, with interrupt 4k+j in bits [8j+7:8j]. The word reads back as written.
- R7: An interrupt that is pending but not enabled is never presented. `win_valid` is high exactly when at least one interrupt is both pending and enabled, and `win_id` then names one of those interrupts.
- R8: Among pending and enabled interrupts, the smallest priority value wins. Equal priority values go to the lower interrupt number.
- R9: An `ack` pulse whose `ack_id` equals `win_id` while `win_valid` is high clears that interrupt's pending bit at the next edge. An `ack` with any other number changes nothing.
- R10: If the acknowledged interrupt's line is high in the same cycle as the `ack`, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | NUM_IRQ | Interrupt request lines, sampled each clock edge |
| bus_addr | input | AW | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ack | input | 1 | Acknowledge pulse |
| ack_id | input | ID_W | Number of the interrupt being acknowledged |
| win_id | output | ID_W | Number of the winning interrupt |
| win_valid | output | 1 | A pending and enabled interrupt exists |

## Verification
Several patterns are applied. A single line is pulsed while its interrupt is disabled, which separates latching from selection. Enable words are written with zeros and with ones through both the set and clear banks, which tells write-one-to-set and write-one-to-clear from plain overwrites. Two enabled interrupts are given lower, equal and higher priority values in turn, which separates "smallest value wins" from lower-number tie breaking. Acknowledges are sent with a wrong number, with the right number, and with the right number while the line is still high. The last interrupt line is also used, so the top word and the top bit of the tree are covered.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int WORD_W        = 32;
  localparam int PRIO_W        = 8;
  localparam int PRIO_PER_WORD = WORD_W / PRIO_W;
endpackage

// File: rtl/irq_flag_bank.sv
// One flag per interrupt: set mask, clear mask, and a force mask that wins last.
module irq_flag_bank #(
  parameter int N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] force_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_n;
  logic         upd;

  always_comb begin
    q_n = ((q_o | set_i) & ~clr_i) | force_i;
    upd = |(set_i | clr_i | force_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= '0;
    else if (upd) q_o <= q_n;
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_pkg::*;
#(
  parameter int N = 256,
  parameter int PWORDS = N / PRIO_PER_WORD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PWORDS-1:0]            wr_word_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [N-1:0][PRIO_W-1:0]     prio_o
);
  for (genvar k = 0; k < PWORDS; k++) begin : g_word
    for (genvar j = 0; j < PRIO_PER_WORD; j++) begin : g_byte
      logic [PRIO_W-1:0] p_n;
      always_comb p_n = wdata_i[j*PRIO_W +: PRIO_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            prio_o[k*PRIO_PER_WORD+j] <= '0;
        else if (wr_word_i[k]) prio_o[k*PRIO_PER_WORD+j] <= p_n;
      end
    end
  end
endmodule

// File: rtl/irq_arb_tree.sv
// Pairwise reduction: the left (lower numbered) side wins ties.
module irq_arb_tree
  import irq_pkg::*;
#(
  parameter int N    = 256,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     valid_o,
  output logic [ID_W-1:0]          id_o
);
  logic [N-1:0]             nv;
  logic [N-1:0][PRIO_W-1:0] np;
  logic [N-1:0][ID_W-1:0]   ni;

  always_comb begin
    nv = cand_i;
    np = prio_i;
    for (int i = 0; i < N; i++) ni[i] = ID_W'(i);
    for (int w = N / 2; w >= 1; w = w / 2) begin
      for (int k = 0; k < w; k++) begin
        if (nv[2*k] && (!nv[2*k+1] || np[2*k] <= np[2*k+1])) begin
          nv[k] = 1'b1;
          np[k] = np[2*k];
          ni[k] = ni[2*k];
        end else begin
          nv[k] = nv[2*k+1];
          np[k] = np[2*k+1];
          ni[k] = ni[2*k+1];
        end
      end
    end
    valid_o = nv[0];
    id_o    = ni[0];
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int ID_W    = $clog2(NUM_IRQ),
  parameter int WORDS   = NUM_IRQ / WORD_W,
  parameter int PWORDS  = NUM_IRQ / PRIO_PER_WORD,
  parameter int AW      = $clog2(4 * WORDS + PWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               ack,
  input  logic [ID_W-1:0]    ack_id,
  output logic [ID_W-1:0]    win_id,
  output logic               win_valid
);
  localparam int SETEN_BASE = 0;
  localparam int CLREN_BASE = WORDS;
  localparam int SETPD_BASE = 2 * WORDS;
  localparam int CLRPD_BASE = 3 * WORDS;
  localparam int PRIO_BASE  = 4 * WORDS;

  // reset: asynchronous assertion, two-flop synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic [NUM_IRQ-1:0]             set_en_vec, clr_en_vec, set_pd_vec, clr_pd_vec;
  logic [NUM_IRQ-1:0]             ack_vec, pd_clr_all, en_q, pend_q;
  logic [PWORDS-1:0]              prio_wr;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic                           clr_en_hit;

  for (genvar w = 0; w < WORDS; w++) begin : g_dec
    always_comb begin
      set_en_vec[w*WORD_W +: WORD_W] = (bus_wr && bus_addr == AW'(SETEN_BASE + w)) ? bus_wdata : '0;
      clr_en_vec[w*WORD_W +: WORD_W] = (bus_wr && bus_addr == AW'(CLREN_BASE + w)) ? bus_wdata : '0;
      set_pd_vec[w*WORD_W +: WORD_W] = (bus_wr && bus_addr == AW'(SETPD_BASE + w)) ? bus_wdata : '0;
      clr_pd_vec[w*WORD_W +: WORD_W] = (bus_wr && bus_addr == AW'(CLRPD_BASE + w)) ? bus_wdata : '0;
    end
  end

  for (genvar k = 0; k < PWORDS; k++) begin : g_pdec
    assign prio_wr[k] = bus_wr && bus_addr == AW'(PRIO_BASE + k);
  end

  always_comb begin
    ack_vec = '0;
    if (ack && win_valid && ack_id == win_id) ack_vec[win_id] = 1'b1;
    pd_clr_all = clr_pd_vec | ack_vec;
    clr_en_hit = |clr_en_vec;
  end

  irq_flag_bank #(.N(NUM_IRQ)) u_en (
    .clk(clk), .rst_n(rst_core_n), .set_i(set_en_vec), .clr_i(clr_en_vec),
    .force_i('0), .q_o(en_q)
  );

  irq_flag_bank #(.N(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_core_n), .set_i(set_pd_vec), .clr_i(pd_clr_all),
    .force_i(irq_lines), .q_o(pend_q)
  );

  irq_prio_bank #(.N(NUM_IRQ), .PWORDS(PWORDS)) u_prio (
    .clk(clk), .rst_n(rst_core_n), .wr_word_i(prio_wr), .wdata_i(bus_wdata), .prio_o(prio_q)
  );

  irq_arb_tree #(.N(NUM_IRQ), .ID_W(ID_W)) u_arb (
    .cand_i(en_q & pend_q), .prio_i(prio_q), .valid_o(win_valid), .id_o(win_id)
  );

  always_comb begin
    int a;
    a = int'(bus_addr);
    bus_rdata = '0;
    if (a < CLREN_BASE)      bus_rdata = en_q[(a - SETEN_BASE) * WORD_W +: WORD_W];
    else if (a < SETPD_BASE) bus_rdata = en_q[(a - CLREN_BASE) * WORD_W +: WORD_W];
    else if (a < CLRPD_BASE) bus_rdata = pend_q[(a - SETPD_BASE) * WORD_W +: WORD_W];
    else if (a < PRIO_BASE)  bus_rdata = pend_q[(a - CLRPD_BASE) * WORD_W +: WORD_W];
    else if (a < PRIO_BASE + PWORDS) begin
      for (int j = 0; j < PRIO_PER_WORD; j++)
        bus_rdata[j*PRIO_W +: PRIO_W] = prio_q[(a - PRIO_BASE) * PRIO_PER_WORD + j];
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N    = 256,
  parameter int ID_W = $clog2(N)
) (
  input logic            clk,
  input logic            rst_ok,
  input logic [N-1:0]    irq_lines,
  input logic [N-1:0]    en_q,
  input logic [N-1:0]    pend_q,
  input logic            win_valid,
  input logic [ID_W-1:0] win_id,
  input logic            en_drop_ok
);
  // R4
  line_latch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_ok |=> ((pend_q & $past(irq_lines)) == $past(irq_lines)));

  // R7
  winner_legal_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    win_valid |-> (en_q[win_id] && pend_q[win_id]));

  // R7
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    win_valid == (|(en_q & pend_q)));

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rst_ok && !en_drop_ok) |=> ((en_q & $past(en_q)) == $past(en_q)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N(NUM_IRQ), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_ok(rst_core_n), .irq_lines(irq_lines), .en_q(en_q),
  .pend_q(pend_q), .win_valid(win_valid), .win_id(win_id), .en_drop_ok(clr_en_hit)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  localparam int N  = 256;
  localparam int IW = 8;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_lines;
  logic [AW-1:0] bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          ack;
  logic [IW-1:0] ack_id, win_id;
  logic          win_valid;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0]   rd;
    logic          vld;
    logic [IW-1:0] id;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .ack_id(ack_id), .win_id(win_id), .win_valid(win_valid)
  );

  // monitor: compares queued expectations mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (bus_rdata !== e.rd || win_valid !== e.vld || (e.vld && win_id !== e.id)) begin
          n_fail++;
          $display("FAIL %s: rdata=%h valid=%0b id=%0d, expected rdata=%h valid=%0b id=%0d",
                   e.tag, bus_rdata, win_valid, win_id, e.rd, e.vld, e.id);
        end
      end
    end
  end

  task automatic check(input int a, input logic [31:0] rd, input logic v,
                       input int id, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = AW'(a);
    e.rd = rd; e.vld = v; e.id = IW'(id); e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    irq_lines[n] = 1'b1;
    @(negedge clk);
    irq_lines = '0;
  endtask

  task automatic do_ack(input int id, input int hold_line);
    @(negedge clk);
    ack = 1'b1; ack_id = IW'(id);
    if (hold_line >= 0) irq_lines[hold_line] = 1'b1;
    @(negedge clk);
    ack = 1'b0; irq_lines = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_lines = '0; bus_addr = '0; bus_wr = 1'b0;
    bus_wdata = '0; ack = 1'b0; ack_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(0,  32'h0, 1'b0, 0, "R1 enable word 0 after reset");
    check(16, 32'h0, 1'b0, 0, "R1 pending word 0 after reset");
    check(95, 32'h0, 1'b0, 0, "R1 top priority word after reset");

    pulse(5);
    check(16, 32'h20, 1'b0, 0, "R4 disabled line latched, R7 not selected");
    check(24, 32'h20, 1'b0, 0, "R5 clear-pending bank reads pending");

    wr(0, 32'h0);
    check(0, 32'h0, 1'b0, 0, "R2 zero write no effect");
    wr(0, 32'h20);
    check(0, 32'h20, 1'b1, 5, "R2 set-enable, R7 winner 5");
    wr(0, 32'h0);
    check(0, 32'h20, 1'b1, 5, "R2 zero write keeps enable");

    wr(8, 32'h20);
    check(8, 32'h0, 1'b0, 0, "R3 clear-enable");
    wr(0, 32'h20);
    check(8, 32'h20, 1'b1, 5, "R3 clear bank reads enable state");

    wr(33, 32'h0000_4000);
    check(33, 32'h0000_4000, 1'b1, 5, "R6 priority byte 1 of word 1");

    wr(1, 32'h100);
    wr(17, 32'h100);
    check(17, 32'h100, 1'b1, 40, "R5 set-pending, R8 lower value wins");

    wr(42, 32'h40);
    check(42, 32'h40, 1'b1, 5, "R8 tie to lower number");
    wr(42, 32'h10);
    check(42, 32'h10, 1'b1, 40, "R8 smaller value wins");

    do_ack(5, -1);
    check(16, 32'h20, 1'b1, 40, "R9 wrong number ignored");
    do_ack(40, -1);
    check(17, 32'h0, 1'b1, 5, "R9 ack clears pending");

    do_ack(5, 5);
    check(16, 32'h20, 1'b1, 5, "R10 line high during ack keeps pending");

    wr(24, 32'h20);
    check(16, 32'h0, 1'b0, 0, "R5 clear-pending");

    wr(7, 32'h8000_0000);
    pulse(255);
    check(23, 32'h8000_0000, 1'b1, 255, "R4 R8 last line selected");
    check(7, 32'h8000_0000, 1'b1, 255, "R2 top enable bit");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule